// File: doc/BRIEF.md
# Correlator Result Sequencer

The block gathers the in-phase and quadrature results of a bank of twelve correlator pairs and places them, one word per clock, on a single shared result bus. A common accumulator and a DMA path sit downstream of that bus. On an epoch strobe, all twenty-four result words are captured into a snapshot register bank in the same cycle. The block then walks through the snapshot in a fixed order. For each channel, in ascending channel order, it sends the I word and then the Q word. A full sweep therefore occupies 24 consecutive bus slots.

Each beat on the bus carries a channel index from 1 to 12 and a tag that tells I from Q. A start-of-sweep marker is raised on the first slot, so the consumer can align its accumulation. A strobe that lands exactly in the final slot makes the next sweep follow with no gap. A strobe that arrives earlier in the sweep is captured at once into a pending bank and raises an overrun pulse. The sweep in progress finishes untouched, and the pending snapshot starts at the following first slot. When no strobe is waiting at the end of a sweep, the bus goes idle.

Top module: `corr_tdm_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_valid_o`, `bus_first_o` and `overrun_o` are all 0.
- R2: An epoch strobe sampled while the bus is idle makes the very next cycle carry slot 0 (channel 1, I) with `bus_valid_o`=1 and `bus_first_o`=1.
- R3: Within a sweep, the slots follow the order ch1 I, ch1 Q, ch2 I, ch2 Q, … ch12 I, ch12 Q. That is 24 beats on consecutive cycles, with `bus_valid_o` held at 1.
- R4: `bus_chan_o` is a 4-bit channel number in the range 1 to 12. `bus_is_q_o` is 0 for an I word and 1 for a Q word. Channel n takes its I word from bits [16(n-1)+15 : 16(n-1)] of `i_res_i` and its Q word from the same bits of `q_res_i`.
- R5: Every word of a sweep equals the input value sampled on the strobe cycle that started the snapshot. Input changes after that strobe have no effect on the sweep.
- R6: If no strobe is pending and none arrives in the final slot, `bus_valid_o` is 0 in the cycle after ch12 Q.
- R7: A strobe sampled during the ch12 Q slot makes the next cycle carry ch1 I of the new snapshot, with `bus_first_o`=1 and no overrun pulse.
- R8: A strobe sampled during any other slot of a running sweep does the following. It raises `overrun_o` for exactly the next cycle. It leaves the running sweep unchanged. Its input values are sent as the following sweep, which starts straight after ch12 Q.
- R9: When several early strobes arrive within one sweep, the snapshot of the last of them is the one sent next.
- R10: `bus_first_o` is 1 only on ch1 I beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| epoch_i | input | 1 | Snapshot strobe for all correlator results |
| i_res_i | input | 192 | Twelve packed 16-bit I results, channel 1 in the low bits |
| q_res_i | input | 192 | Twelve packed 16-bit Q results, channel 1 in the low bits |
| bus_valid_o | output | 1 | Bus beat valid |
| bus_data_o | output | 16 | Result word on the bus |
| bus_chan_o | output | 4 | Channel number of the beat, 1 to 12 |
| bus_is_q_o | output | 1 | 0 = I word, 1 = Q word |
| bus_first_o | output | 1 | Start-of-sweep marker (ch1 I) |
| overrun_o | output | 1 | One-cycle pulse after a strobe that arrived mid-sweep |

## Verification
The bench targets the strobe that lands exactly on the ch12 Q slot. A design with an off-by-one in its end-of-sweep test would either flag a false overrun there or insert an idle gap before the next sweep. It changes the live inputs right after every strobe, which exposes a design that muxes live correlator outputs instead of the snapshot. It fires two early strobes in one sweep, so a design that keeps the first pending capture, or that corrupts the running sweep with pending data, sends wrong words. It also checks the idle beat after a lone sweep, which catches a counter that wraps and keeps replaying old data.

// File: rtl/corr_tdm_pkg.sv
// Package: shared types for the correlator result sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package corr_tdm_pkg;

    // Sequencer control state: idle bus or a sweep in progress.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/corr_tdm_bank.sv
// Module: corr_tdm_bank
// Holds one registered copy of every channel's I and Q result. All words
// load together when load_i is high, so a copy always comes from one instant.
// Assumes: packed inputs, channel 0 in the least significant word.
module corr_tdm_bank #(
    parameter int NUM_CH = 12,
    parameter int DATA_W = 16
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       load_i,
    input  logic [NUM_CH*DATA_W-1:0]   i_flat_i,
    input  logic [NUM_CH*DATA_W-1:0]   q_flat_i,
    output logic [NUM_CH*DATA_W-1:0]   i_flat_o,
    output logic [NUM_CH*DATA_W-1:0]   q_flat_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [DATA_W-1:0] i_word_q;
        logic [DATA_W-1:0] q_word_q;

        // Capture this channel's pair on a load request.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                i_word_q <= '0;
                q_word_q <= '0;
            end else if (load_i) begin
                i_word_q <= i_flat_i[c*DATA_W +: DATA_W];
                q_word_q <= q_flat_i[c*DATA_W +: DATA_W];
            end
        end

        assign i_flat_o[c*DATA_W +: DATA_W] = i_word_q;
        assign q_flat_o[c*DATA_W +: DATA_W] = q_word_q;
    end

endmodule

// File: rtl/corr_tdm_ctrl.sv
// Module: corr_tdm_ctrl
// Slot counter and sweep control. It starts a sweep on a strobe when idle,
// chains sweeps at the final slot, and parks early strobes as a pending
// snapshot while raising a one-cycle overrun pulse.
// Assumes: NUM_SLOTS is even and fits in SLOT_W bits.
module corr_tdm_ctrl
    import corr_tdm_pkg::*;
#(
    parameter int NUM_SLOTS = 24,
    parameter int SLOT_W    = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              epoch_i,
    output logic              busy_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              act_load_o,
    output logic              act_from_pend_o,
    output logic              pend_load_o,
    output logic              overrun_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    seq_state_e        state_q;
    logic [SLOT_W-1:0] slot_q;
    logic              pend_q;
    logic              overrun_q;
    logic              busy;
    logic              last;
    logic              start_idle;
    logic              start_wrap;

    // Decode the sweep boundary and the load requests.
    always_comb begin
        busy            = (state_q == SEQ_RUN);
        last            = busy && (slot_q == LAST_SLOT);
        start_idle      = !busy && epoch_i;
        start_wrap      = last && (epoch_i || pend_q);
        act_load_o      = start_idle || start_wrap;
        act_from_pend_o = last && pend_q && !epoch_i;
        pend_load_o     = busy && !last && epoch_i;
    end

    // Track whether a sweep is running.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)         state_q <= SEQ_IDLE;
        else if (act_load_o) state_q <= SEQ_RUN;
        else if (last)       state_q <= SEQ_IDLE;
    end

    // Advance the bus slot, restarting at slot 0 on every new snapshot.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)         slot_q <= '0;
        else if (act_load_o) slot_q <= '0;
        else if (busy)       slot_q <= slot_q + SLOT_W'(1);
    end

    // Remember that an early snapshot waits in the pending bank.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)          pend_q <= 1'b0;
        else if (pend_load_o) pend_q <= 1'b1;
        else if (last)        pend_q <= 1'b0;
    end

    // Pulse overrun in the cycle after an early strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) overrun_q <= 1'b0;
        else         overrun_q <= pend_load_o;
    end

    assign busy_o    = busy;
    assign slot_o    = slot_q;
    assign overrun_o = overrun_q;

endmodule

// File: rtl/corr_tdm_outmux.sv
// Module: corr_tdm_outmux
// Turns the slot number into a bus beat. Slot bit 0 selects I or Q, and the
// upper bits select the channel. Data comes from the active snapshot only.
// Assumes: slot values stay below 2*NUM_CH.
module corr_tdm_outmux #(
    parameter int NUM_CH = 12,
    parameter int DATA_W = 16,
    parameter int SLOT_W = 5,
    parameter int CH_W   = 4
) (
    input  logic                     busy_i,
    input  logic [SLOT_W-1:0]        slot_i,
    input  logic [NUM_CH*DATA_W-1:0] i_flat_i,
    input  logic [NUM_CH*DATA_W-1:0] q_flat_i,
    output logic                     valid_o,
    output logic [DATA_W-1:0]        data_o,
    output logic [CH_W-1:0]          chan_o,
    output logic                     is_q_o,
    output logic                     first_o
);

    localparam int CHS_W = SLOT_W - 1;

    logic [CHS_W-1:0] ch_sel;
    logic             q_sel;

    // Split the slot number into channel and I/Q parts.
    always_comb begin
        ch_sel = slot_i[SLOT_W-1:1];
        q_sel  = slot_i[0];
    end

    // Select the word of the addressed channel and half.
    always_comb begin
        data_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_sel == CHS_W'(c)) begin
                data_o = q_sel ? q_flat_i[c*DATA_W +: DATA_W]
                               : i_flat_i[c*DATA_W +: DATA_W];
            end
        end
    end

    // Form the beat side-band fields.
    always_comb begin
        valid_o = busy_i;
        chan_o  = CH_W'(ch_sel) + CH_W'(1);
        is_q_o  = q_sel;
        first_o = busy_i && (slot_i == '0);
    end

endmodule

// File: rtl/corr_tdm_sequencer.sv
// Module: corr_tdm_sequencer (top)
// Serialises twelve correlator I/Q result pairs onto one bus in I-then-Q,
// ascending-channel order. An active bank feeds the bus, and a pending bank
// holds a snapshot taken by a strobe that arrived mid-sweep.
// Assumes: epoch_i is synchronous to clk_i. Consumers take one beat per cycle.
module corr_tdm_sequencer #(
    parameter int NUM_CH = 12,
    parameter int DATA_W = 16,
    parameter int CH_W   = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     epoch_i,
    input  logic [NUM_CH*DATA_W-1:0] i_res_i,
    input  logic [NUM_CH*DATA_W-1:0] q_res_i,
    output logic                     bus_valid_o,
    output logic [DATA_W-1:0]        bus_data_o,
    output logic [CH_W-1:0]          bus_chan_o,
    output logic                     bus_is_q_o,
    output logic                     bus_first_o,
    output logic                     overrun_o
);

    localparam int NUM_SLOTS = 2 * NUM_CH;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int FLAT_W    = NUM_CH * DATA_W;

    logic              busy;
    logic [SLOT_W-1:0] slot;
    logic              act_load;
    logic              act_from_pend;
    logic              pend_load;
    logic [FLAT_W-1:0] pend_i;
    logic [FLAT_W-1:0] pend_q;
    logic [FLAT_W-1:0] act_src_i;
    logic [FLAT_W-1:0] act_src_q;
    logic [FLAT_W-1:0] act_i;
    logic [FLAT_W-1:0] act_q;

    corr_tdm_ctrl #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_ctrl (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .epoch_i         (epoch_i),
        .busy_o          (busy),
        .slot_o          (slot),
        .act_load_o      (act_load),
        .act_from_pend_o (act_from_pend),
        .pend_load_o     (pend_load),
        .overrun_o       (overrun_o)
    );

    corr_tdm_bank #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_pend_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (pend_load),
        .i_flat_i (i_res_i),
        .q_flat_i (q_res_i),
        .i_flat_o (pend_i),
        .q_flat_o (pend_q)
    );

    // Choose the active bank source: the pending bank or the live inputs.
    always_comb begin
        act_src_i = act_from_pend ? pend_i : i_res_i;
        act_src_q = act_from_pend ? pend_q : q_res_i;
    end

    corr_tdm_bank #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_act_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (act_load),
        .i_flat_i (act_src_i),
        .q_flat_i (act_src_q),
        .i_flat_o (act_i),
        .q_flat_o (act_q)
    );

    corr_tdm_outmux #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .SLOT_W (SLOT_W),
        .CH_W   (CH_W)
    ) u_outmux (
        .busy_i   (busy),
        .slot_i   (slot),
        .i_flat_i (act_i),
        .q_flat_i (act_q),
        .valid_o  (bus_valid_o),
        .data_o   (bus_data_o),
        .chan_o   (bus_chan_o),
        .is_q_o   (bus_is_q_o),
        .first_o  (bus_first_o)
    );

endmodule

// File: rtl/corr_tdm_sequencer_chk.sv
// Module: corr_tdm_sequencer_chk
// Port-level protocol checks for the sequencer. It is bound to the top module.
// Assumes: synchronous active-low reset. All checks are disabled during reset.
module corr_tdm_sequencer_chk #(
    parameter int NUM_CH = 12,
    parameter int CH_W   = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            epoch_i,
    input logic            bus_valid_o,
    input logic [CH_W-1:0] bus_chan_o,
    input logic            bus_is_q_o,
    input logic            bus_first_o,
    input logic            overrun_o
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH);

    // R2: a strobe on an idle bus opens a sweep on the next beat.
    a_r2_idle_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_valid_o && epoch_i) |=> (bus_valid_o && bus_first_o));

    // R3: an I beat is followed by the Q beat of the same channel.
    a_r3_i_then_q: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_valid_o && !bus_is_q_o) |=>
            (bus_valid_o && bus_is_q_o && bus_chan_o == $past(bus_chan_o)));

    // R3: a Q beat below the last channel is followed by the next channel's I beat.
    a_r3_next_chan: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_valid_o && bus_is_q_o && bus_chan_o != LAST_CH) |=>
            (bus_valid_o && !bus_is_q_o && bus_chan_o == $past(bus_chan_o) + CH_W'(1)));

    // R4: the channel number stays within 1..NUM_CH.
    a_r4_chan_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_valid_o |-> (bus_chan_o >= CH_W'(1) && bus_chan_o <= LAST_CH));

    // R7: after the last Q beat, the bus is either idle or back at the first slot.
    a_r7_wrap_to_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_valid_o && bus_is_q_o && bus_chan_o == LAST_CH) |=>
            (!bus_valid_o || bus_first_o));

    // R8: a strobe before the final slot causes an overrun pulse.
    a_r8_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (epoch_i && bus_valid_o && !(bus_is_q_o && bus_chan_o == LAST_CH)) |=> overrun_o);

    // R8: an overrun pulse only follows a strobe during a running sweep.
    a_r8_overrun_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overrun_o |-> ($past(epoch_i) && $past(bus_valid_o)));

    // R10: the start marker sits on channel 1 I beats only.
    a_r10_first_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_first_o |-> (bus_valid_o && !bus_is_q_o && bus_chan_o == CH_W'(1)));

endmodule

bind corr_tdm_sequencer corr_tdm_sequencer_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .epoch_i     (epoch_i),
    .bus_valid_o (bus_valid_o),
    .bus_chan_o  (bus_chan_o),
    .bus_is_q_o  (bus_is_q_o),
    .bus_first_o (bus_first_o),
    .overrun_o   (overrun_o)
);

// File: tb/corr_tdm_sequencer_tb_top.sv
// Self-checking bench for corr_tdm_sequencer: a table-driven sweep loop,
// then directed tests for reset, chaining, overrun and latest-wins.
module corr_tdm_sequencer_tb_top;

    localparam int NUM_CH = 12;
    localparam int DATA_W = 16;
    localparam int CH_W   = 4;
    localparam int NSLOT  = 2 * NUM_CH;
    localparam int NVEC   = 4;

    // Each entry holds a base value in the upper half and a per-channel step in the lower half.
    localparam logic [31:0] VEC_TAB [NVEC] = '{
        32'h0100_0011, 32'hF000_0203, 32'h0000_0001, 32'h7FF0_1111
    };

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     epoch = 1'b0;
    logic [NUM_CH*DATA_W-1:0] i_flat;
    logic [NUM_CH*DATA_W-1:0] q_flat;
    logic                     bus_valid;
    logic [DATA_W-1:0]        bus_data;
    logic [CH_W-1:0]          bus_chan;
    logic                     bus_is_q;
    logic                     bus_first;
    logic                     overrun;

    logic [DATA_W-1:0] ti [NUM_CH];
    logic [DATA_W-1:0] tq [NUM_CH];
    logic [DATA_W-1:0] ni [NUM_CH];
    logic [DATA_W-1:0] nq [NUM_CH];
    logic [DATA_W-1:0] ei [NUM_CH];
    logic [DATA_W-1:0] eq [NUM_CH];

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            i_flat[c*DATA_W +: DATA_W] = ti[c];
            q_flat[c*DATA_W +: DATA_W] = tq[c];
        end
    end

    corr_tdm_sequencer #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .CH_W   (CH_W)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .epoch_i     (epoch),
        .i_res_i     (i_flat),
        .q_res_i     (q_flat),
        .bus_valid_o (bus_valid),
        .bus_data_o  (bus_data),
        .bus_chan_o  (bus_chan),
        .bus_is_q_o  (bus_is_q),
        .bus_first_o (bus_first),
        .overrun_o   (overrun)
    );

    task automatic set_pattern(input logic [15:0] base, input logic [15:0] step);
        for (int c = 0; c < NUM_CH; c++) begin
            ti[c] = base + 16'(c) * step;
            tq[c] = ~base - 16'(c) * step - 16'h0300;
        end
    endtask

    task automatic snap_next();
        ni = ti;
        nq = tq;
    endtask

    task automatic promote();
        ei = ni;
        eq = nq;
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    // Compare one bus beat with the expected slot of the current snapshot.
    task automatic chk_beat(input int s, input string req);
        int               ch;
        logic             xq;
        logic [15:0]      xd;
        ch = s / 2;
        xq = (s % 2) == 1;
        xd = xq ? eq[ch] : ei[ch];
        n_checks++;
        if (bus_valid !== 1'b1 || bus_chan !== CH_W'(ch + 1) || bus_is_q !== xq ||
            bus_data !== xd || bus_first !== (s == 0)) begin
            n_errors++;
            $display("FAIL %s slot %0d: got v=%b ch=%0d q=%b d=%h f=%b expected v=1 ch=%0d q=%b d=%h f=%b",
                     req, s, bus_valid, bus_chan, bus_is_q, bus_data, bus_first,
                     ch + 1, xq, xd, (s == 0));
        end
    endtask

    // Start a sweep from idle and stop at the negedge that shows slot 0.
    task automatic start_sweep(input logic [15:0] base, input logic [15:0] step);
        @(negedge clk);
        set_pattern(base, step);
        epoch = 1'b1;
        snap_next();
        @(negedge clk);
        epoch = 1'b0;
        promote();
        set_pattern(16'hDEAD, 16'h0101);
    endtask

    initial begin
        #(5ns * 100000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        set_pattern(16'h1234, 16'h0001);
        repeat (3) @(negedge clk);
        chk_bit(bus_valid, 1'b0, "R1", "valid in reset");
        chk_bit(bus_first, 1'b0, "R1", "first in reset");
        chk_bit(overrun,   1'b0, "R1", "overrun in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit(bus_valid, 1'b0, "R1", "valid after reset");
        chk_bit(overrun,   1'b0, "R1", "overrun after reset");

        // Table walk: R2 R3 R4 R5 R10, then idle after the sweep (R6).
        for (int v = 0; v < NVEC; v++) begin
            start_sweep(VEC_TAB[v][31:16], VEC_TAB[v][15:0]);
            for (int s = 0; s < NSLOT; s++) begin
                if (s > 0) @(negedge clk);
                chk_beat(s, (s == 0) ? "R2 R3 R4 R5 R10" : "R3 R4 R5 R10");
            end
            @(negedge clk);
            chk_bit(bus_valid, 1'b0, "R6", "valid after last Q");
            repeat (2) @(negedge clk);
        end

        // R7: a strobe in the final slot chains the next sweep with no gap.
        start_sweep(16'h2000, 16'h0020);
        for (int s = 0; s < NSLOT; s++) begin
            if (s > 0) @(negedge clk);
            chk_beat(s, "R7");
            if (s == NSLOT - 1) begin
                set_pattern(16'h3300, 16'h0007);
                epoch = 1'b1;
                snap_next();
            end
        end
        @(negedge clk);
        epoch = 1'b0;
        promote();
        set_pattern(16'hBEEF, 16'h0002);
        chk_bit(overrun, 1'b0, "R7", "overrun on final-slot strobe");
        for (int s = 0; s < NSLOT; s++) begin
            if (s > 0) @(negedge clk);
            chk_beat(s, "R7");
        end
        @(negedge clk);
        chk_bit(bus_valid, 1'b0, "R6", "valid after chained sweep");
        repeat (2) @(negedge clk);

        // R8 and R9: two early strobes; the running sweep stays intact and the later one wins.
        start_sweep(16'h4000, 16'h0100);
        for (int s = 0; s < NSLOT; s++) begin
            if (s > 0) @(negedge clk);
            epoch = 1'b0;
            chk_beat(s, "R8");
            if (s == 6 || s == 11) chk_bit(overrun, 1'b1, "R8", "overrun after early strobe");
            if (s == 7) chk_bit(overrun, 1'b0, "R8", "overrun pulse width");
            if (s == 5) begin
                set_pattern(16'h5000, 16'h0003);
                epoch = 1'b1;
                snap_next();
            end else if (s == 10) begin
                set_pattern(16'h6A00, 16'h0031);
                epoch = 1'b1;
                snap_next();
            end else begin
                set_pattern(16'h0F0F, 16'h0404);
            end
        end
        @(negedge clk);
        promote();
        for (int s = 0; s < NSLOT; s++) begin
            if (s > 0) @(negedge clk);
            chk_beat(s, "R9");
        end
        @(negedge clk);
        chk_bit(bus_valid, 1'b0, "R6", "valid after pending sweep");
        chk_bit(overrun,   1'b0, "R8", "overrun idle");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule